// File: doc/BRIEF.md
# I/O Page-Table Walk Translator

This block turns a device-side virtual address into a 36-bit physical address. It uses a single-level table of 32-bit entries held in memory. A requester hands in an address and a read/write flag on a valid/ready handshake. The walker then:

- forms the byte address of the table entry from a base register and a window-start value;
- issues one memory read for that entry;
- inspects the returned word;
- answers with either a physical address plus a permission code, or a fault.

Pages are 4 KB. The entry word arrives on a big-endian 32-bit lane by default. A parameter can byte-reverse it.

When a walk faults, the block writes a syndrome word and the faulting page address into the surrounding register file. It does this with a one-cycle strobe, and the same strobe raises the interrupt. Only one walk is in flight at a time.

The base and window inputs are configuration. They must stay stable while a walk is in progress.

Top module: `io_walk_xlate`

## Requirements
- R1: The entry read address is (cfg_base << 4) + (((page AND NOT cfg_win) >> 10) AND NOT 3), computed 36 bits wide. Here page is req_va with bits [11:0] cleared.
- R2: req_ready is 1 only while no walk is in progress and no response is pending. A request is accepted only when req_valid and req_ready are both 1.
- R3: Each accepted request produces exactly one memory read request. mem_req_valid stays 1 with a stable address until mem_req_ready, and drops in the cycle after the read is accepted.
- R4: For an entry that permits the access, rsp_pa = {entry[31:8], req_va[11:0]}, and rsp_fault = 0.
- R5: The permission code on a successful walk is 2'b11 (read-write) when entry bit 2 is set, and 2'b01 (read-only) when it is clear.
- R6: An entry with bit 1 (valid) clear gives rsp_fault = 1, rsp_perm = 2'b00 and rsp_pa = 0. This holds whatever the other bits are.
- R7: A write through an entry with bit 2 clear faults exactly as in R6. A read through the same entry succeeds.
- R8: A fault pulses flt_post for exactly one cycle, in the first cycle rsp_valid is 1. In that cycle:
  - flt_status is 0xC0820000 for a write and 0xC0860000 for a read (bit 18 marks a read);
  - flt_addr is the page address.
- R9: The response fields stay unchanged while rsp_valid is 1 and rsp_ready is 0. The response retires on rsp_valid and rsp_ready.
- R10: Entry bit 7 (cacheable) and bits [6:3] and [0] have no effect on the response.
- R11: After reset, req_ready = 1, while rsp_valid, mem_req_valid and flt_post are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can accept a request |
| req_va | input | 32 | Device virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| cfg_base | input | 32 | Table base register |
| cfg_win | input | 32 | Window start address; its set bits are removed before indexing |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 36 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 36 | Physical address (0 on fault) |
| rsp_perm | output | 2 | 00 none, 01 read-only, 11 read-write |
| rsp_fault | output | 1 | Walk faulted |
| flt_post | output | 1 | One-cycle fault write strobe and interrupt raise |
| flt_status | output | 32 | Fault syndrome word |
| flt_addr | output | 32 | Faulting page address |

## Verification
Walks are driven with several kinds of entry, so that each outcome is separated from the others:
- read-write and read-only entries, which separate the two permission codes;
- entries with the valid bit clear, including one that also has the writable bit set, which shows that the valid check dominates;
- write and read accesses to a read-only entry, which isolate the permission check;
- an entry with the cacheable and spare bits set, compared against a clean one.

Two window sizes and page-offset extremes show that the window bits are removed and the offset passes through unchanged. Varying the memory latency and the requester stall shows that the read request and the response are held until accepted. It also shows that the fault strobe fires once and not for every stalled cycle.

// File: rtl/iow_pkg.sv
package iow_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_FETCH   = 2'd1,
      ST_CHECK   = 2'd2,
      ST_RESPOND = 2'd3
   } walk_st_e;

   localparam logic [1:0] PERM_NONE = 2'b00;
   localparam logic [1:0] PERM_RO   = 2'b01;
   localparam logic [1:0] PERM_RW   = 2'b11;

   localparam int PTE_VALID_BIT = 1;
   localparam int PTE_WRITE_BIT = 2;
   localparam int PTE_PPN_LSB   = 8;

   localparam logic [31:0] FLT_SYNDROME_BASE = 32'hC082_0000;
   localparam int          FLT_READ_BIT      = 18;

endpackage

// File: rtl/iow_pte_addr.sv
module iow_pte_addr #(
   parameter int VA_W       = 32,
   parameter int PA_W       = 36,
   parameter int BASE_W     = 32,
   parameter int PG_SHIFT   = 12,
   parameter int BASE_SHIFT = 4
) (
   input  logic [BASE_W-1:0] base,
   input  logic [VA_W-1:0]   win,
   input  logic [VA_W-1:0]   va,
   output logic [PA_W-1:0]   pte_addr
);
   localparam int IDX_SHIFT = PG_SHIFT - 2;

   generate
      if (PA_W < BASE_W + BASE_SHIFT) begin : g_bad_width
         $error("PA_W too narrow for shifted base");
      end
      if (PG_SHIFT < 3) begin : g_bad_page
         $error("PG_SHIFT must be at least 3");
      end
   endgenerate

   logic [VA_W-1:0] page;
   logic [VA_W-1:0] rel;
   logic [PA_W-1:0] base_ext;
   logic [PA_W-1:0] idx_ext;

   always_comb begin
      page     = va & ~VA_W'((64'd1 << PG_SHIFT) - 64'd1);
      rel      = page & ~win;
      base_ext = PA_W'(base) << BASE_SHIFT;
      idx_ext  = PA_W'(rel >> IDX_SHIFT) & ~PA_W'(3);
      pte_addr = base_ext + idx_ext;
   end
endmodule

// File: rtl/iow_pte_eval.sv
module iow_pte_eval
   import iow_pkg::*;
#(
   parameter int VA_W       = 32,
   parameter int PA_W       = 36,
   parameter int PG_SHIFT   = 12,
   parameter int ENTRY_W    = 32,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic [ENTRY_W-1:0] raw,
   input  logic [VA_W-1:0]    va,
   input  logic               is_wr,
   output logic [PA_W-1:0]    pa,
   output logic [1:0]         perm,
   output logic               fault,
   output logic [31:0]        syn,
   output logic [VA_W-1:0]    page
);
   localparam int PPN_W = PA_W - PG_SHIFT;

   logic [ENTRY_W-1:0] word;

   generate
      if (ENTRY_W - PTE_PPN_LSB != PPN_W) begin : g_bad_ppn
         $error("entry page field does not fit PA_W - PG_SHIFT");
      end
      if (ENTRY_W % 8 != 0) begin : g_bad_entry
         $error("ENTRY_W must be a byte multiple");
      end

      if (BIG_ENDIAN) begin : g_be
         assign word = raw;
      end else begin : g_le
         for (genvar b = 0; b < ENTRY_W/8; b++) begin : g_swap
            assign word[8*b +: 8] = raw[ENTRY_W-8-8*b +: 8];
         end
      end
   endgenerate

   logic unused_entry_bits;
   assign unused_entry_bits = ^{word[PTE_PPN_LSB-1:PTE_WRITE_BIT+1], word[0]};

   logic ok_valid, ok_write;

   always_comb begin
      ok_valid = word[PTE_VALID_BIT];
      ok_write = word[PTE_WRITE_BIT];
      fault    = !ok_valid || (is_wr && !ok_write);
      page     = va & ~VA_W'((64'd1 << PG_SHIFT) - 64'd1);

      if (fault) begin
         pa   = '0;
         perm = PERM_NONE;
      end else begin
         pa   = {word[ENTRY_W-1:PTE_PPN_LSB], va[PG_SHIFT-1:0]};
         perm = ok_write ? PERM_RW : PERM_RO;
      end

      syn = FLT_SYNDROME_BASE;
      syn[FLT_READ_BIT] = !is_wr;
   end
endmodule

// File: rtl/io_walk_xlate.sv
module io_walk_xlate
   import iow_pkg::*;
#(
   parameter int VA_W           = 32,
   parameter int PA_W           = 36,
   parameter int BASE_W         = 32,
   parameter int PG_SHIFT       = 12,
   parameter int ENTRY_W        = 32,
   parameter bit MEM_BIG_ENDIAN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [VA_W-1:0]    req_va,
   input  logic               req_write,
   input  logic [BASE_W-1:0]  cfg_base,
   input  logic [VA_W-1:0]    cfg_win,
   output logic               mem_req_valid,
   input  logic               mem_req_ready,
   output logic [PA_W-1:0]    mem_req_addr,
   input  logic               mem_rsp_valid,
   input  logic [ENTRY_W-1:0] mem_rsp_data,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [PA_W-1:0]    rsp_pa,
   output logic [1:0]         rsp_perm,
   output logic               rsp_fault,
   output logic               flt_post,
   output logic [31:0]        flt_status,
   output logic [VA_W-1:0]    flt_addr
);
   walk_st_e           st_q;
   logic [VA_W-1:0]    va_q;
   logic               wr_q;
   logic               issued_q;
   logic [ENTRY_W-1:0] entry_q;

   logic [PA_W-1:0]    ev_pa;
   logic [1:0]         ev_perm;
   logic               ev_fault;
   logic [31:0]        ev_syn;
   logic [VA_W-1:0]    ev_page;

   iow_pte_addr #(
      .VA_W(VA_W), .PA_W(PA_W), .BASE_W(BASE_W), .PG_SHIFT(PG_SHIFT), .BASE_SHIFT(4)
   ) u_addr (
      .base(cfg_base), .win(cfg_win), .va(va_q), .pte_addr(mem_req_addr)
   );

   iow_pte_eval #(
      .VA_W(VA_W), .PA_W(PA_W), .PG_SHIFT(PG_SHIFT), .ENTRY_W(ENTRY_W),
      .BIG_ENDIAN(MEM_BIG_ENDIAN)
   ) u_eval (
      .raw(entry_q), .va(va_q), .is_wr(wr_q),
      .pa(ev_pa), .perm(ev_perm), .fault(ev_fault), .syn(ev_syn), .page(ev_page)
   );

   assign req_ready     = (st_q == ST_IDLE);
   assign mem_req_valid = (st_q == ST_FETCH) && !issued_q;
   assign rsp_valid     = (st_q == ST_RESPOND);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         va_q       <= '0;
         wr_q       <= 1'b0;
         issued_q   <= 1'b0;
         entry_q    <= '0;
         rsp_pa     <= '0;
         rsp_perm   <= PERM_NONE;
         rsp_fault  <= 1'b0;
         flt_post   <= 1'b0;
         flt_status <= '0;
         flt_addr   <= '0;
      end else begin
         flt_post <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (req_valid) begin
                  va_q     <= req_va;
                  wr_q     <= req_write;
                  issued_q <= 1'b0;
                  st_q     <= ST_FETCH;
               end
            end
            ST_FETCH: begin
               if (!issued_q) begin
                  if (mem_req_ready) issued_q <= 1'b1;
               end else if (mem_rsp_valid) begin
                  entry_q <= mem_rsp_data;
                  st_q    <= ST_CHECK;
               end
            end
            ST_CHECK: begin
               rsp_pa    <= ev_pa;
               rsp_perm  <= ev_perm;
               rsp_fault <= ev_fault;
               if (ev_fault) begin
                  flt_post   <= 1'b1;
                  flt_status <= ev_syn;
                  flt_addr   <= ev_page;
               end
               st_q <= ST_RESPOND;
            end
            ST_RESPOND: begin
               if (rsp_ready) st_q <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   a_r2_ready_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!rsp_valid && !mem_req_valid));

   a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   a_r3_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

   a_r6_fault_no_perm: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault) |-> (rsp_perm == PERM_NONE && rsp_pa == '0));

   a_r8_flt_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      flt_post |-> (rsp_valid && rsp_fault && flt_status[31]));

   a_r8_flt_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      flt_post |=> !flt_post);

   a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa)
                                     && $stable(rsp_perm) && $stable(rsp_fault)));
endmodule

// File: tb/io_walk_xlate_tb.sv
module io_walk_xlate_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_va = '0;
   logic        req_write = 1'b0;
   logic [31:0] cfg_base = '0;
   logic [31:0] cfg_win = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [35:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [35:0] rsp_pa;
   logic [1:0]  rsp_perm;
   logic        rsp_fault;
   logic        flt_post;
   logic [31:0] flt_status;
   logic [31:0] flt_addr;

   always #5 clk = ~clk;

   io_walk_xlate u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va), .req_write(req_write),
      .cfg_base(cfg_base), .cfg_win(cfg_win),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_pa(rsp_pa), .rsp_perm(rsp_perm),
      .rsp_fault(rsp_fault), .flt_post(flt_post), .flt_status(flt_status), .flt_addr(flt_addr)
   );

   typedef struct {
      logic [35:0] pte;
      logic [31:0] entry;
      int          lat;
      int          stall;
      logic [35:0] pa;
      logic [1:0]  perm;
      logic        fault;
      logic [31:0] fstat;
      logic [31:0] faddr;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_chk = 0;
   int   n_bad = 0;
   int   pending = 0;
   bit   finished = 1'b0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
   endtask

   // driver: computes expectations from the requirements and issues one request
   task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] base,
                       input logic [31:0] win, input logic [31:0] entry,
                       input int lat, input int stall, input string tag);
      exp_t e;
      logic [31:0] page;
      bit          fault;
      page    = va & 32'hFFFF_F000;
      e.pte   = ({4'h0, base} << 4) + (({4'h0, page & ~win}) >> 10) & ~36'h3;
      fault   = !entry[1] || (wr && !entry[2]);
      e.entry = entry;
      e.lat   = lat;
      e.stall = stall;
      e.fault = fault;
      e.pa    = fault ? 36'h0 : {entry[31:8], va[11:0]};
      e.perm  = fault ? 2'b00 : (entry[2] ? 2'b11 : 2'b01);
      e.fstat = 32'hC082_0000 | (wr ? 32'h0 : 32'h0004_0000);
      e.faddr = page;
      e.tag   = tag;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      cfg_base  = base;
      cfg_win   = win;
      req_va    = va;
      req_write = wr;
      req_valid = 1'b1;
      exp_q.push_back(e);
      pending++;
      @(posedge clk);
      #1 req_valid = 1'b0;
      req_va = 32'hDEAD_BEEF;
      wait (pending == 0);
   endtask

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req_valid && exp_q.size() > 0) begin
            exp_t e;
            e = exp_q[0];
            chk(mem_req_addr == e.pte, {"R1 entry address ", e.tag}, 64'(mem_req_addr), 64'(e.pte));
            chk(!req_ready, {"R2 ready low during fetch ", e.tag}, 64'(req_ready), 64'd0);
            for (int i = 0; i < e.lat; i++) begin
               @(negedge clk);
               chk(mem_req_valid && mem_req_addr == e.pte, {"R3 read held ", e.tag},
                   64'(mem_req_valid), 64'd1);
            end
            mem_req_ready = 1'b1;
            @(posedge clk);
            #1 mem_req_ready = 1'b0;
            @(negedge clk);
            chk(!mem_req_valid, {"R3 read drops after accept ", e.tag}, 64'(mem_req_valid), 64'd0);
            for (int i = 0; i < e.lat; i++) @(negedge clk);
            mem_rsp_data  = e.entry;
            mem_rsp_valid = 1'b1;
            @(posedge clk);
            #1 mem_rsp_valid = 1'b0;
            mem_rsp_data = 32'h0;
         end
      end
   end

   // response monitor / scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rsp_valid) begin
            exp_t e;
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2 response without request", 64'd1, 64'd0);
            end else begin
               e = exp_q.pop_front();
               chk(rsp_fault == e.fault, {"R6/R7 fault flag ", e.tag}, 64'(rsp_fault), 64'(e.fault));
               chk(rsp_pa == e.pa, {"R4 physical address ", e.tag}, 64'(rsp_pa), 64'(e.pa));
               chk(rsp_perm == e.perm, {"R5 permission ", e.tag}, 64'(rsp_perm), 64'(e.perm));
               chk(!req_ready, {"R2 ready low while responding ", e.tag}, 64'(req_ready), 64'd0);
               chk(flt_post == e.fault, {"R8 fault strobe ", e.tag}, 64'(flt_post), 64'(e.fault));
               if (e.fault) begin
                  chk(flt_status == e.fstat, {"R8 syndrome ", e.tag}, 64'(flt_status), 64'(e.fstat));
                  chk(flt_addr == e.faddr, {"R8 fault address ", e.tag}, 64'(flt_addr), 64'(e.faddr));
               end
               for (int i = 0; i < e.stall; i++) begin
                  @(negedge clk);
                  chk(rsp_valid && rsp_pa == e.pa && rsp_perm == e.perm && rsp_fault == e.fault,
                      {"R9 response held ", e.tag}, 64'(rsp_pa), 64'(e.pa));
                  chk(!flt_post, {"R8 strobe single cycle ", e.tag}, 64'(flt_post), 64'd0);
               end
               rsp_ready = 1'b1;
               @(posedge clk);
               #1 rsp_ready = 1'b0;
               pending--;
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired actual=hung expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R11 reset req_ready", 64'(req_ready), 64'd1);
      chk(!rsp_valid && !mem_req_valid, "R11 reset rsp/mem valid", 64'({rsp_valid, mem_req_valid}), 64'd0);
      chk(!flt_post, "R11 reset flt_post", 64'(flt_post), 64'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      walk(32'hFF12_3456, 1'b0, 32'h0001_2340, 32'hFF00_0000, 32'hABCD_EF06, 0, 0, "R4 R5 rw read");
      walk(32'hFF12_3FFF, 1'b0, 32'h0001_2340, 32'hFF00_0000, 32'h1234_5602, 1, 0, "R5 ro read");
      walk(32'hFF00_0000, 1'b1, 32'h0001_2340, 32'hFF00_0000, 32'h1234_5602, 0, 1, "R7 write to ro");
      walk(32'hFFFF_F123, 1'b0, 32'h0000_1000, 32'hFF00_0000, 32'h5555_5500, 2, 0, "R6 invalid read");
      walk(32'hFF00_1ABC, 1'b1, 32'h0000_1000, 32'hFF00_0000, 32'hFFFF_FF04, 0, 0, "R6 invalid but writable");
      walk(32'hFE80_0000, 1'b1, 32'h0FFF_FFF0, 32'hFE00_0000, 32'h8000_0106, 3, 2, "R4 R9 rw write stall");
      walk(32'hFE80_0000, 1'b1, 32'h0FFF_FFF0, 32'hFE00_0000, 32'h8000_01FF, 1, 0, "R10 cacheable spare bits");
      walk(32'hFFFF_FFFF, 1'b0, 32'h0000_0400, 32'h8000_0000, 32'hFFFF_FF86, 0, 3, "R1 R10 2GB window top");
      walk(32'h8000_0000, 1'b0, 32'h0000_0400, 32'h8000_0000, 32'h0000_0102, 0, 0, "R1 2GB window bottom");
      walk(32'hF0AB_C000, 1'b0, 32'h0000_0400, 32'hF000_0000, 32'h0000_0000, 1, 2, "R6 R9 zero entry");

      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid && !mem_req_valid, "R2 idle after all walks", 64'(req_ready), 64'd1);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule